// File: doc/BRIEF.md
# Area-Based External Bus Controller

This block converts requests from an internal master into cycles on an external memory bus. The 16 MB external space is cut into eight equal 2 MB windows, selected by the top three address bits. Each window has its own active-low chip select. Each window also has its own settings: an 8-bit or 16-bit data path, a short (two-clock) or long (three-clock) cycle, and up to three extra wait clocks that stretch only long cycles. A word request to a byte-wide window becomes two byte cycles, the high byte first at the even address.

The requester raises `req_valid` with a stable address, direction, size and write data. It holds them until `req_ready` pulses for one clock, in the last state of the access, with read data valid on `req_rdata` in that same clock. Between two accesses the bus always rests for at least one clock. Two optional enables add one more quiet clock before an access when the previous access was a read: one covers a read that follows it in a different window, the other covers any write that follows it.

Top module: `area_bus_ctrl`

## Requirements
- R1: The window index is `req_addr[23:21]`. During every state of an access, only `ext_cs_n[index]` is low. It stays low without a break across both byte cycles of a split word. When no access runs, all chip selects are high.
- R2: In a 16-bit window, a word access is a single cycle at the even address with all 16 data bits. A byte read at an even address returns `ext_din[15:8]` and at an odd address returns `ext_din[7:0]`, placed in `req_rdata[7:0]` with the upper byte zero.
- R3: In an 8-bit window, data moves on `ext_din[7:0]`. A word access runs two byte cycles, at the even address (high byte, `req_wdata[15:8]` / `req_rdata[15:8]`) and then at the odd address (low byte). Ready comes only at the end of the second cycle.
- R4: A window with the long-cycle bit clear takes exactly 2 clocks per byte cycle, whatever its wait field holds.
- R5: A window with the long-cycle bit set takes 3 + W clocks per byte cycle, where W (0..3) is its 2-bit wait field `cfg_wait[2i+1:2i]`.
- R6: In the first clock of each byte cycle both strobes are high. From the second clock through the last clock of the cycle, `ext_rd_n` (read) or `ext_wr_n` (write) is low. The other strobe stays high, and no strobe is ever low without a chip select.
- R7: `ext_doe` is high in every clock of a write cycle and low otherwise. A 16-bit word write drives `req_wdata` on `ext_dout`. Every byte cycle drives its byte on both halves of `ext_dout`.
- R8: With `idle_rr_en` set, a read that follows a read to a different window gets one extra clock with all chip selects and strobes high. A read that follows a read to the same window gets none, and none is added when the enable is clear.
- R9: With `idle_rw_en` set, a write that follows a read gets one extra quiet clock. A write that follows a write gets none.
- R10: `req_ready` is high for exactly one clock, in the final clock of the access, while the strobe is still low.
- R11: After reset, all chip selects and both strobes are high, and `ext_doe` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read data, valid with ready |
| cfg_wide | input | 8 | Per window: 1 = 16-bit data path |
| cfg_three | input | 8 | Per window: 1 = long (three-clock) cycle |
| cfg_wait | input | 16 | Per window 2-bit wait count, window i at bits 2i+1:2i |
| idle_rr_en | input | 1 | Enable quiet clock for read after read to another window |
| idle_rw_en | input | 1 | Enable quiet clock for write after read |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | External data output enable |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_cs_n | output | 8 | Chip selects, active low, one per window |

## Verification
The bench goes after the clock count of each window type. It checks a short window whose wait field is non-zero, which a design that applied waits everywhere would stretch, and a long window with three waits, which an off-by-one wait counter would cut short or lengthen. Split words in a byte-wide window are checked for byte order, address sequence and an unbroken chip select. A design that returned ready after the first byte, or swapped the halves, would fail there. The quiet-clock rules are exercised on same-window and cross-window reads, on writes after writes, and with the enables cleared. Each of these shows up as a latency that is one clock wrong.

// File: rtl/abc_pkg.sv
package abc_pkg;
  localparam int WAIT_W = 2;
  localparam int DW     = 16;
  localparam int BW     = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_T1, ST_T2, ST_TW, ST_T3
  } bus_st_e;

  typedef struct packed {
    logic              wide;
    logic              three;
    logic [WAIT_W-1:0] waits;
  } area_cfg_t;

  // byte lane chosen by a byte read: wide bus puts the even byte high
  function automatic logic [BW-1:0] pick_lane(logic [DW-1:0] d, logic wide, logic odd);
    if (!wide)    return d[BW-1:0];
    else if (odd) return d[BW-1:0];
    else          return d[DW-1:BW];
  endfunction

  // final clock of one byte cycle
  function automatic logic is_last(bus_st_e st, logic three);
    return (st == ST_T2 && !three) || (st == ST_T3);
  endfunction
endpackage

// File: rtl/abc_area_sel.sv
module abc_area_sel
  import abc_pkg::*;
#(
  parameter int AW     = 24,
  parameter int N_AREA = 8,
  parameter int IW     = $clog2(N_AREA)
) (
  input  logic [AW-1:0]            addr,
  input  logic [N_AREA-1:0]        cfg_wide,
  input  logic [N_AREA-1:0]        cfg_three,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  output logic [IW-1:0]            area,
  output area_cfg_t                cfg
);
  area_cfg_t tbl [N_AREA];

  for (genvar g = 0; g < N_AREA; g++) begin : g_tbl
    assign tbl[g] = '{wide:  cfg_wide[g],
                      three: cfg_three[g],
                      waits: cfg_wait[g*WAIT_W +: WAIT_W]};
  end

  assign area = addr[AW-1 -: IW];
  assign cfg  = tbl[area];
endmodule

// File: rtl/abc_seq.sv
module abc_seq
  import abc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              need_idle,
  input  logic              split,
  input  logic              three,
  input  logic [WAIT_W-1:0] waits,
  output bus_st_e           st,
  output logic              phase,
  output logic              byte_end,
  output logic              acc_done
);
  logic [WAIT_W-1:0] wcnt;

  assign byte_end = is_last(st, three);
  assign acc_done = byte_end && (!split || phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      phase <= 1'b0;
      wcnt  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          phase <= 1'b0;
          if (req_valid) st <= need_idle ? ST_GAP : ST_T1;
        end
        ST_GAP: st <= ST_T1;
        ST_T1:  st <= ST_T2;
        ST_T2: begin
          if (three) begin
            wcnt <= {{(WAIT_W-1){1'b0}}, 1'b1};
            st   <= (waits != '0) ? ST_TW : ST_T3;
          end
        end
        ST_TW: begin
          if (wcnt == waits) st <= ST_T3;
          else               wcnt <= wcnt + 1'b1;
        end
        default: ;
      endcase
      if (byte_end) begin
        if (split && !phase) begin
          phase <= 1'b1;
          st    <= ST_T1;
        end else begin
          st <= ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/area_bus_ctrl.sv
module area_bus_ctrl
  import abc_pkg::*;
#(
  parameter int AW     = 24,
  parameter int N_AREA = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     req_ready,
  output logic [DW-1:0]            req_rdata,
  input  logic [N_AREA-1:0]        cfg_wide,
  input  logic [N_AREA-1:0]        cfg_three,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  input  logic                     idle_rr_en,
  input  logic                     idle_rw_en,
  output logic [AW-1:0]            ext_addr,
  output logic [DW-1:0]            ext_dout,
  output logic                     ext_doe,
  input  logic [DW-1:0]            ext_din,
  output logic                     ext_rd_n,
  output logic                     ext_wr_n,
  output logic [N_AREA-1:0]        ext_cs_n
);
  localparam int IW = $clog2(N_AREA);

  logic [IW-1:0] area;
  area_cfg_t     acfg;
  bus_st_e       st;
  logic          phase, byte_end, acc_done, gap_now;
  logic          split, wide_word, need_idle;
  logic          prev_vld, prev_rd;
  logic [IW-1:0] prev_area;
  logic [BW-1:0] hi_q, wbyte;
  logic          active, strobe;

  abc_area_sel #(.AW(AW), .N_AREA(N_AREA), .IW(IW)) u_sel (
    .addr(req_addr), .cfg_wide(cfg_wide), .cfg_three(cfg_three),
    .cfg_wait(cfg_wait), .area(area), .cfg(acfg)
  );

  assign wide_word = req_word &&  acfg.wide;
  assign split     = req_word && !acfg.wide;
  assign need_idle = prev_vld && prev_rd &&
                     ((!req_write && idle_rr_en && (area != prev_area)) ||
                      ( req_write && idle_rw_en));

  abc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .need_idle(need_idle),
    .split(split), .three(acfg.three), .waits(acfg.waits),
    .st(st), .phase(phase), .byte_end(byte_end), .acc_done(acc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld  <= 1'b0;
      prev_rd   <= 1'b0;
      prev_area <= '0;
      hi_q      <= '0;
    end else begin
      if (acc_done) begin
        prev_vld  <= 1'b1;
        prev_rd   <= !req_write;
        prev_area <= area;
      end
      if (byte_end && split && !phase && !req_write) hi_q <= ext_din[BW-1:0];
    end
  end

  assign gap_now = (st == ST_GAP);
  assign active  = (st == ST_T1) || (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
  assign strobe  = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);

  always_comb begin
    ext_cs_n = '1;
    if (active) ext_cs_n[area] = 1'b0;
  end

  assign ext_rd_n  = !(strobe && !req_write);
  assign ext_wr_n  = !(strobe &&  req_write);
  assign ext_doe   = active && req_write;
  assign req_ready = acc_done;

  assign wbyte    = (split && !phase) ? req_wdata[DW-1:BW] : req_wdata[BW-1:0];
  assign ext_dout = wide_word ? req_wdata : {wbyte, wbyte};
  assign ext_addr = wide_word ? {req_addr[AW-1:1], 1'b0} :
                    split     ? {req_addr[AW-1:1], phase} : req_addr;

  assign req_rdata = wide_word ? ext_din :
                     split     ? {hi_q, ext_din[BW-1:0]} :
                     {{BW{1'b0}}, pick_lane(ext_din, acfg.wide, req_addr[0])};
endmodule

// File: rtl/abc_chk.sv
module abc_chk #(
  parameter int N_AREA = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ext_rd_n,
  input logic              ext_wr_n,
  input logic              ext_doe,
  input logic [N_AREA-1:0] ext_cs_n,
  input logic              gap_now,
  input logic              byte_end
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ext_cs_n) <= 1);                                             // R1
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_n != '1 && !req_ready) |=> (ext_cs_n == $past(ext_cs_n)));       // R1
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now |-> (&ext_cs_n && ext_rd_n && ext_wr_n));                        // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));                                              // R6
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> (ext_cs_n != '1));                          // R6
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&ext_cs_n) |-> (ext_rd_n && ext_wr_n));                            // R6
  AST_SPLIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && !req_ready) |=> (ext_rd_n && ext_wr_n));                    // R3
  AST_DOE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_doe |-> (ext_rd_n && ext_cs_n != '1));                               // R7
  AST_READY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);                                               // R10
  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ext_rd_n || !ext_wr_n));                                 // R10
endmodule

bind area_bus_ctrl abc_chk #(.N_AREA(N_AREA)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ext_rd_n(ext_rd_n),
  .ext_wr_n(ext_wr_n), .ext_doe(ext_doe), .ext_cs_n(ext_cs_n),
  .gap_now(gap_now), .byte_end(byte_end)
);

// File: tb/tb_area_bus_ctrl.sv
module tb_area_bus_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] req_rdata;
  logic [7:0]  cfg_wide, cfg_three;
  logic [15:0] cfg_wait;
  logic        idle_rr_en = 1'b0, idle_rw_en = 1'b0;
  logic [23:0] ext_addr;
  logic [15:0] ext_dout, ext_din;
  logic        ext_doe, ext_rd_n, ext_wr_n;
  logic [7:0]  ext_cs_n;

  int n_chk = 0, n_fail = 0;
  logic       m_vld = 1'b0, m_rd = 1'b0;
  logic [2:0] m_area = '0;

  always #(CLK_P/2) clk = ~clk;

  area_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .cfg_wide(cfg_wide),
    .cfg_three(cfg_three), .cfg_wait(cfg_wait), .idle_rr_en(idle_rr_en),
    .idle_rw_en(idle_rw_en), .ext_addr(ext_addr), .ext_dout(ext_dout),
    .ext_doe(ext_doe), .ext_din(ext_din), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_cs_n(ext_cs_n)
  );

  // memory content: one byte per address
  function automatic logic [7:0] bv(logic [23:0] a);
    return a[7:0] ^ 8'hA5 ^ {5'b0, a[23:21]};
  endfunction

  // external devices: 16-bit parts put the even byte high, 8-bit parts use the low half
  always_comb begin
    if (cfg_wide[ext_addr[23:21]])
      ext_din = {bv({ext_addr[23:1], 1'b0}), bv({ext_addr[23:1], 1'b1})};
    else
      ext_din = {8'hEE, bv(ext_addr)};
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic wrd, input logic [23:0] a,
                        input logic [15:0] w, input string lat_tag, input string dat_tag);
    logic [2:0]  ar;
    logic        wide, three, split, idl;
    int          wv, len, ncyc, exp_lat, n, k, c, p;
    int          e_cs, e_stb, e_doe, e_adr, e_dat;
    logic [23:0] ea;
    logic [15:0] ed, got, exp_rd;
    ar = a[23:21];
    wide = cfg_wide[ar]; three = cfg_three[ar];
    wv = int'(cfg_wait[2*ar +: 2]);
    len = three ? 3 + wv : 2;
    split = wrd && !wide;
    ncyc = split ? 2 : 1;
    idl = m_vld && m_rd && ((!wr && idle_rr_en && ar != m_area) || (wr && idle_rw_en));
    exp_lat = (idl ? 1 : 0) + len * ncyc;
    e_cs = 0; e_stb = 0; e_doe = 0; e_adr = 0; e_dat = 0; got = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wrd; req_addr = a; req_wdata = w;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (idl && n == 1) begin
        if (ext_cs_n != 8'hFF || !ext_rd_n || !ext_wr_n) e_cs++;
      end else begin
        k = n - 1 - (idl ? 1 : 0);
        c = k / len; p = k % len;
        if (ext_cs_n != ~(8'h01 << ar)) e_cs++;
        if (p == 0) begin
          if (!ext_rd_n || !ext_wr_n) e_stb++;
        end else if (wr) begin
          if (ext_wr_n || !ext_rd_n) e_stb++;
        end else begin
          if (ext_rd_n || !ext_wr_n) e_stb++;
        end
        if (ext_doe != wr) e_doe++;
        ea = (wrd && wide) ? {a[23:1], 1'b0} : split ? {a[23:1], (c == 1)} : a;
        if (ext_addr != ea) e_adr++;
        if (wr) begin
          ed = (wrd && wide) ? w : (split && c == 0) ? {w[15:8], w[15:8]} : {w[7:0], w[7:0]};
          if (ext_dout != ed) e_dat++;
        end
      end
      if (req_ready) begin got = req_rdata; break; end
      if (n > 64) break;
    end
    req_valid = 1'b0;
    chk(n == exp_lat, lat_tag, "clocks to ready", n, exp_lat);
    chk(e_cs == 0, "R1", "chip select mismatches", e_cs, 0);
    chk(e_stb == 0, "R6", "strobe mismatches", e_stb, 0);
    chk(e_doe == 0, "R7", "output enable mismatches", e_doe, 0);
    chk(e_adr == 0, dat_tag, "address mismatches", e_adr, 0);
    if (wr) chk(e_dat == 0, "R7", "write data mismatches", e_dat, 0);
    else begin
      exp_rd = wrd ? {bv({a[23:1], 1'b0}), bv({a[23:1], 1'b1})} : {8'h00, bv(a)};
      chk(got == exp_rd, dat_tag, "read data", got, exp_rd);
    end
    @(negedge clk);
    chk(!req_ready, "R10", "ready after final clock", req_ready, 0);
    m_vld = 1'b1; m_rd = !wr; m_area = ar;
  endtask

  task automatic t_reset;
    chk(ext_cs_n == 8'hFF, "R11", "chip selects", ext_cs_n, 8'hFF);
    chk(ext_rd_n && ext_wr_n, "R11", "strobes", {ext_rd_n, ext_wr_n}, 2'b11);
    chk(!ext_doe && !req_ready, "R11", "doe/ready", {ext_doe, req_ready}, 0);
  endtask

  task automatic t_wide_bus;
    do_acc(0, 1, 24'h000100, 16'h0, "R4", "R2");
    do_acc(0, 0, 24'h000102, 16'h0, "R4", "R2");
    do_acc(0, 0, 24'h000103, 16'h0, "R4", "R2");
    do_acc(1, 1, 24'h000104, 16'hBEEF, "R4", "R2");
    do_acc(1, 0, 24'h000107, 16'h0042, "R4", "R2");
  endtask

  task automatic t_narrow_bus;
    do_acc(0, 1, 24'h200010, 16'h0, "R3", "R3");
    do_acc(1, 1, 24'h200020, 16'h1234, "R3", "R3");
    do_acc(0, 0, 24'h200031, 16'h0, "R3", "R3");
  endtask

  task automatic t_state_count;
    do_acc(0, 1, 24'h400000, 16'h0, "R5", "R2");
    do_acc(0, 1, 24'h600002, 16'h0, "R5", "R2");
    do_acc(0, 1, 24'h800004, 16'h0, "R5", "R3");
    do_acc(0, 1, 24'hA00000, 16'h0, "R4", "R2");
  endtask

  task automatic t_idle_rr;
    idle_rr_en = 1'b1;
    do_acc(0, 1, 24'h000200, 16'h0, "R8", "R2");
    do_acc(0, 1, 24'h200200, 16'h0, "R8", "R3");
    do_acc(0, 0, 24'h200201, 16'h0, "R8", "R3");
    do_acc(1, 0, 24'h200202, 16'h0077, "R8", "R3");
    do_acc(0, 1, 24'h400010, 16'h0, "R8", "R2");
    idle_rr_en = 1'b0;
    do_acc(0, 1, 24'h000210, 16'h0, "R8", "R2");
  endtask

  task automatic t_idle_rw;
    idle_rw_en = 1'b1;
    do_acc(0, 1, 24'h000300, 16'h0, "R9", "R2");
    do_acc(1, 1, 24'h000302, 16'hA55A, "R9", "R2");
    do_acc(1, 1, 24'h000304, 16'h5AA5, "R9", "R2");
    do_acc(0, 1, 24'h600100, 16'h0, "R9", "R2");
    do_acc(1, 1, 24'h400100, 16'hC3C3, "R9", "R2");
    idle_rw_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // windows: 0 wide/short, 1 byte/short, 2 wide/long W0, 3 wide/long W3,
    // 4 byte/long W2, 5 wide/short with wait field 3, 6 and 7 wide/short
    cfg_wide  = 8'b1110_1101;
    cfg_three = 8'b0001_1100;
    cfg_wait  = {2'd0, 2'd0, 2'd3, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0};
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_wide_bus;
    t_narrow_bus;
    t_state_count;
    t_idle_rr;
    t_idle_rw;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule